// File: doc/BRIEF.md
# Masked GPIO Port Register Bank

This block controls a 32-pin general-purpose I/O port from a small memory-mapped register bus. Software picks each pin's direction, drives output pins through an output latch, and samples the pins through a pin-value register. The latch can be changed in three ways. A direct load through the pin-value register replaces bits. A set register turns bits on, and a clear register turns bits off. Every register accepts full-word, half-word and single-byte writes, chosen by the byte enables.

A per-pin mask register limits which pins software may touch. A pin whose mask bit is 1 ignores all latch writes made through the set, clear and pin-value registers. That pin's bit in the pin-value read also stays frozen at its last captured value. This lets one piece of software own some pins without read-modify-write races against code that owns the others.

The block has no sequencing state machine. A bus access is decoded and completed in one clock cycle. Read data is registered and holds until the next read.

Top module: `gmp_port`

## Requirements
- R1: After reset, the direction, mask and output-latch registers are all zero. The captured pin-value register and `bus_rdata` are also zero. Therefore `pin_oe` and `pin_out` are zero.
- R2: The register at byte offset 0x00 sets pin direction. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. `pin_oe` equals this register from the clock edge that completes the write.
- R3: A write changes only the byte lanes whose `bus_be` bit is 1. Bit k of `bus_be` covers data bits 8k+7..8k. So `bus_be` = 4'b0011 writes the lower half-word (pins 0–15), 4'b1100 writes the upper half-word (pins 16–31), and a single bit writes one byte.
- R4: Writing the set register (offset 0x18) sets to 1 every unmasked, enabled latch bit whose write-data bit is 1. Bits written as 0 stay as they were. Reading offset 0x18 returns the output latch. `pin_out` shows the latch.
- R5: Writing the clear register (offset 0x1C) clears to 0 every unmasked, enabled latch bit whose write-data bit is 1. Bits written as 0 stay as they were. Reading offset 0x1C returns zero.
- R6: Writing the pin-value register (offset 0x14) loads the write data directly into the unmasked, enabled latch bits.
- R7: A latch bit whose mask bit is 1 does not change on any write to offset 0x14, 0x18 or 0x1C.
- R8: Reading offset 0x14 returns, for each unmasked pin, its live state. An output pin shows its latch bit. An input pin shows `pin_i` as it was at the previous clock edge.
- R9: For each pin whose mask bit is 1, a read of offset 0x14 returns that bit's previously captured value, which is 0 after reset.
- R10: `bus_rdata` is updated at the clock edge that takes a read and holds its value until the next read. Offsets 0x04, 0x08 and 0x0C read as zero, and writes to them change nothing. `bus_addr[1:0]` is ignored.
- R11: The mask register at offset 0x10 is read and written like the direction register, including lane writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] choose the register |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_i | input | 32 | Pin input levels |
| pin_oe | output | 32 | Per-pin output enable (the direction register) |
| pin_out | output | 32 | Per-pin output value (the output latch) |

## Verification
Results are due at different times after a stimulus:

- A write shows on `pin_oe` and `pin_out` right after the clock edge that takes it.
- A read shows on `bus_rdata` right after its edge.
- A change on `pin_i` needs one extra edge before a read can see it, because of the input sampling register.

The bench drives every access at a falling edge and reads the outputs at the next falling edge, after the single register stage. When a read is meant to observe new pin levels, the bench leaves one idle cycle between changing `pin_i` and issuing the read. A behavioural model that follows the same edge-by-edge schedule is compared with all three outputs at every falling edge.

// File: rtl/gmp_pkg.sv
package gmp_pkg;

    // Word index (byte address bits [4:2]) of each register.
    typedef enum logic [2:0] {
        RS_DIR  = 3'd0,
        RS_MASK = 3'd4,
        RS_PIN  = 3'd5,
        RS_SET  = 3'd6,
        RS_CLR  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gmp_lane_merge.sv
module gmp_lane_merge #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]   old_val,
    input  logic [DATA_W-1:0]   new_val,
    input  logic [DATA_W/8-1:0] lane_en,
    output logic [DATA_W-1:0]   merged,
    output logic [DATA_W-1:0]   lane_bits
);
    localparam int unsigned LANES = DATA_W / 8;

    // Each byte lane either takes the new data or keeps the old value.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g*8 +: 8] = {8{lane_en[g]}};
        assign merged[g*8 +: 8]    = lane_en[g] ? new_val[g*8 +: 8] : old_val[g*8 +: 8];
    end
endmodule

// File: rtl/gmp_pin_capture.sv
module gmp_pin_capture #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pin_i,
    input  logic [DATA_W-1:0] dir_q,
    input  logic [DATA_W-1:0] lat_q,
    input  logic [DATA_W-1:0] mask_q,
    input  logic              cap_stb,
    output logic [DATA_W-1:0] cap_next
);
    logic [DATA_W-1:0] pin_q;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] live;

    // Output pins show the latch; input pins show the sampled level.
    assign live     = (dir_q & lat_q) | (~dir_q & pin_q);
    // Masked bits keep the previously captured value.
    assign cap_next = (cap_q & mask_q) | (live & ~mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
            cap_q <= '0;
        end else begin
            pin_q <= pin_i;
            if (cap_stb) begin
                cap_q <= cap_next;
            end
        end
    end

    // R9
    masked_cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q ^ $past(cap_q)) & $past(mask_q)) == '0);
endmodule

// File: rtl/gmp_port.sv
module gmp_port
    import gmp_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_sel,
    input  logic                             bus_we,
    input  logic [$clog2(DATA_W/8)+2:0]      bus_addr,
    input  logic [DATA_W/8-1:0]              bus_be,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    input  logic [DATA_W-1:0]                pin_i,
    output logic [DATA_W-1:0]                pin_oe,
    output logic [DATA_W-1:0]                pin_out
);
    localparam int unsigned LANES    = DATA_W / 8;
    localparam int unsigned WORD_LSB = $clog2(LANES);

    logic [DATA_W-1:0] dir_q, mask_q, lat_q, rdata_q;
    logic [DATA_W-1:0] dir_d, mask_d, lat_d, rd_d;
    logic [DATA_W-1:0] dir_mrg, mask_mrg, lat_mrg;
    logic [DATA_W-1:0] lane_v, lane_unused_a, lane_unused_b;
    logic [DATA_W-1:0] wr_eff, cap_next;
    logic              wr_stb, rd_stb, cap_stb;
    logic              unused_addr_lsb;
    reg_sel_e          rsel;

    assign unused_addr_lsb = ^bus_addr[WORD_LSB-1:0];
    assign rsel    = reg_sel_e'(bus_addr[WORD_LSB +: 3]);
    assign wr_stb  = bus_sel & bus_we;
    assign rd_stb  = bus_sel & ~bus_we;
    assign cap_stb = rd_stb & (rsel == RS_PIN);
    // Write bits that are enabled by a lane and not masked.
    assign wr_eff  = bus_wdata & lane_v & ~mask_q;

    gmp_lane_merge #(.DATA_W(DATA_W)) u_dir_mrg (
        .old_val(dir_q), .new_val(bus_wdata), .lane_en(bus_be),
        .merged(dir_mrg), .lane_bits(lane_v)
    );
    gmp_lane_merge #(.DATA_W(DATA_W)) u_mask_mrg (
        .old_val(mask_q), .new_val(bus_wdata), .lane_en(bus_be),
        .merged(mask_mrg), .lane_bits(lane_unused_a)
    );
    gmp_lane_merge #(.DATA_W(DATA_W)) u_lat_mrg (
        .old_val(lat_q), .new_val(bus_wdata), .lane_en(bus_be),
        .merged(lat_mrg), .lane_bits(lane_unused_b)
    );

    gmp_pin_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .dir_q(dir_q),
        .lat_q(lat_q), .mask_q(mask_q), .cap_stb(cap_stb),
        .cap_next(cap_next)
    );

    // Next-state for the writable registers.
    always_comb begin
        dir_d  = dir_q;
        mask_d = mask_q;
        lat_d  = lat_q;
        if (wr_stb) begin
            unique case (rsel)
                RS_DIR:  dir_d  = dir_mrg;
                RS_MASK: mask_d = mask_mrg;
                RS_PIN:  lat_d  = (lat_q & mask_q) | (lat_mrg & ~mask_q);
                RS_SET:  lat_d  = lat_q | wr_eff;
                RS_CLR:  lat_d  = lat_q & ~wr_eff;
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (rsel)
            RS_DIR:  rd_d = dir_q;
            RS_MASK: rd_d = mask_q;
            RS_PIN:  rd_d = cap_next;
            RS_SET:  rd_d = lat_q;
            RS_CLR:  rd_d = '0;
            default: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            mask_q  <= '0;
            lat_q   <= '0;
            rdata_q <= '0;
        end else begin
            dir_q  <= dir_d;
            mask_q <= mask_d;
            lat_q  <= lat_d;
            if (rd_stb) begin
                rdata_q <= rd_d;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign pin_oe    = dir_q;
    assign pin_out   = lat_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && bus_rdata == '0));

    // R7
    masked_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0);

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rsel == RS_SET) |=>
        ((pin_out & $past(wr_eff)) == $past(wr_eff) &&
         ((pin_out ^ $past(pin_out)) & ~$past(wr_eff)) == '0));

    // R5
    clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rsel == RS_CLR) |=>
        ((pin_out & $past(wr_eff)) == '0 &&
         ((pin_out ^ $past(pin_out)) & ~$past(wr_eff)) == '0));

    // R10
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !(rsel inside {RS_DIR, RS_MASK, RS_PIN, RS_SET, RS_CLR})) |=>
        ($stable(pin_oe) && $stable(pin_out) && $stable(mask_q)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(bus_rdata));
endmodule

// File: tb/gmp_port_tb_top.sv
module gmp_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [4:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wd = '0, pin_in = '0;
    logic [31:0] rdata, oe, pout;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    gmp_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr), .bus_be(be), .bus_wdata(wd), .bus_rdata(rdata),
        .pin_i(pin_in), .pin_oe(oe), .pin_out(pout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    logic [31:0] m_dir = '0, m_mask = '0, m_lat = '0, m_cap = '0, m_rd = '0, m_pq = '0;
    always @(posedge clk) begin : model
        logic [31:0] ln, live, eff, nlat;
        if (!rst_n) begin
            m_dir = '0; m_mask = '0; m_lat = '0; m_cap = '0; m_rd = '0; m_pq = '0;
        end else begin
            ln   = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            live = (m_dir & m_lat) | (~m_dir & m_pq);
            eff  = wd & ln & ~m_mask;
            nlat = m_lat;
            if (sel && !we) begin
                case (addr[4:2])
                    3'd0: m_rd = m_dir;
                    3'd4: m_rd = m_mask;
                    3'd5: begin
                        m_cap = (m_cap & m_mask) | (live & ~m_mask);
                        m_rd  = m_cap;
                    end
                    3'd6: m_rd = m_lat;
                    default: m_rd = '0;
                endcase
            end
            if (sel && we) begin
                case (addr[4:2])
                    3'd0: m_dir  = (m_dir & ~ln) | (wd & ln);
                    3'd4: m_mask = (m_mask & ~ln) | (wd & ln);
                    3'd5: nlat   = (m_lat & ~eff & ~(ln & ~m_mask)) | eff;
                    3'd6: nlat   = m_lat | eff;
                    3'd7: nlat   = m_lat & ~eff;
                    default: ;
                endcase
            end
            m_lat = nlat;
            m_pq  = pin_in;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 pin_oe vs model", oe, m_dir);
            chk("R6 pin_out vs model", pout, m_lat);
            chk("R8 bus_rdata vs model", rdata, m_rd);
        end
    end

    task automatic wr(input logic [4:0] a, input logic [3:0] b, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; be = b; wd = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] q);
        sel = 1'b1; we = 1'b0; addr = a; be = 4'hF;
        @(negedge clk);
        q = rdata;
        sel = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        chk("R1 pin_oe reset", oe, 32'h0);
        chk("R1 pin_out reset", pout, 32'h0);
        chk("R1 rdata reset", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: masked capture starts at zero
        wr(5'h10, 4'hF, 32'hFFFF_FFFF);
        pin_in = 32'hFFFF_FFFF;
        @(negedge clk);
        rd(5'h14, q); chk("R9 masked capture from reset", q, 32'h0);
        wr(5'h10, 4'hF, 32'h0);
        pin_in = 32'h0;
        @(negedge clk);
        rd(5'h14, q); chk("R1 pin value after reset", q, 32'h0);

        // R2 direction
        wr(5'h00, 4'hF, 32'h0000_FFFF);
        chk("R2 oe after word write", oe, 32'h0000_FFFF);
        rd(5'h00, q); chk("R2 direction readback", q, 32'h0000_FFFF);

        // R3 lanes
        wr(5'h00, 4'b0100, 32'h00AB_0000);
        chk("R3 byte lane 2", oe, 32'h00AB_FFFF);
        wr(5'h02, 4'b1100, 32'h1234_0000);
        chk("R3 upper half-word", oe, 32'h1234_FFFF);
        wr(5'h00, 4'hF, 32'hFFFF_FFFF);

        // R4 set
        wr(5'h18, 4'hF, 32'h0000_00F0);
        chk("R4 set bits", pout, 32'h0000_00F0);
        rd(5'h18, q); chk("R4 set reg reads latch", q, 32'h0000_00F0);
        wr(5'h18, 4'hF, 32'h0);
        chk("R4 zero write no effect", pout, 32'h0000_00F0);

        // R5 clear
        wr(5'h1C, 4'hF, 32'h0000_0030);
        chk("R5 clear bits", pout, 32'h0000_00C0);
        rd(5'h1C, q); chk("R5 clear reg reads zero", q, 32'h0);

        // R6 direct load through lanes
        wr(5'h14, 4'b0011, 32'hA5A5_A5A5);
        chk("R6 pin write lower half", pout, 32'h0000_A5A5);

        // R11 mask, R7 masked writes
        wr(5'h10, 4'hF, 32'h0000_00FF);
        rd(5'h10, q); chk("R11 mask readback", q, 32'h0000_00FF);
        wr(5'h18, 4'hF, 32'hFFFF_FFFF);
        chk("R7 set blocked on masked", pout, 32'hFFFF_FFA5);
        wr(5'h1C, 4'hF, 32'hFFFF_FFFF);
        chk("R7 clear blocked on masked", pout, 32'h0000_00A5);
        wr(5'h14, 4'hF, 32'h0);
        chk("R7 pin write blocked on masked", pout, 32'h0000_00A5);
        wr(5'h11, 4'b0010, 32'h0000_0000);
        rd(5'h10, q); chk("R11 mask byte write", q, 32'h0000_00FF);
        wr(5'h10, 4'b0001, 32'h0);
        rd(5'h10, q); chk("R11 mask cleared", q, 32'h0);

        // R8 live read
        wr(5'h00, 4'hF, 32'h0000_FFFF);
        pin_in = 32'hDEAD_0000;
        @(negedge clk);
        rd(5'h14, q); chk("R8 live pin read", q, 32'hDEAD_00A5);

        // R9 frozen masked bits
        wr(5'h10, 4'hF, 32'hFFFF_0000);
        pin_in = 32'h1234_0000;
        @(negedge clk);
        rd(5'h14, q); chk("R9 masked bits held", q, 32'hDEAD_00A5);
        wr(5'h10, 4'hF, 32'h0);
        rd(5'h14, q); chk("R8 unmasked refresh", q, 32'h1234_00A5);

        // R10 unmapped
        wr(5'h04, 4'hF, 32'hFFFF_FFFF);
        chk("R10 unmapped write oe", oe, 32'h0000_FFFF);
        chk("R10 unmapped write out", pout, 32'h0000_00A5);
        rd(5'h08, q); chk("R10 unmapped read", q, 32'h0);
        rd(5'h0C, q); chk("R10 unmapped read 0x0C", q, 32'h0);
        rd(5'h18, q);
        @(negedge clk);
        chk("R10 rdata holds", rdata, 32'h0000_00A5);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule